// File: doc/BRIEF.md
# Vertex Texel Fetch Mode Selector

This block sits in front of a vertex texture cache and decides, for each texel request, how the texel should be fetched. In cache mode the whole 2-D texel block that holds the texel is loaded into the cache with one burst. In direct mode only the single requested texel is read from external memory. The choice comes from a locality estimate. The block takes the absolute coordinate distance to the previous request, estimates from it how many texels of the block will be touched, and compares that estimate with a break-even count. The break-even count is derived at elaboration time from the per-texel direct read cost and the block size.

A window of pending requests is presented alongside the current request. If any valid pending request falls in the same texel block as the current one, cache mode is forced, whatever the distance test decided. Each accepted request produces one registered result: the mode bit and the block address (the coordinates shifted right by the block edge exponent). Requests enter and results leave through valid/ready handshakes.

Top module: `texfetch_mode_sel`

## Requirements
- R1: With default parameters (4x4 texel blocks of 16 texels, direct read cost 8 cycles), the break-even count is 3. For a request with a previous request and nonzero distances du and dv, cache mode (out_cache = 1) is chosen when 3*du*dv <= 16 and direct mode (out_cache = 0) otherwise. So du*dv = 5 selects cache and du*dv = 6 selects direct.
- R2: If either distance du or dv is zero and a previous request exists, cache mode is chosen.
- R3: The first request after reset has no predecessor. It selects cache mode only if the same-block test hits, and direct mode otherwise.
- R4: If any lookahead slot i with look_valid[i] = 1 holds coordinates whose block address equals that of the current request, cache mode is forced. Slot i occupies bits [i*CW +: CW] of look_u and look_v.
- R5: The result carries out_bu = in_u >> EDGE_LOG2 and out_bv = in_v >> EDGE_LOG2 of the request it belongs to.
- R6: Distances are absolute differences, so a step toward smaller coordinates is judged like the same step toward larger ones.
- R7: in_ready is high whenever out_valid is low or out_ready is high. While out_valid is high and out_ready is low, the result holds steady.
- R8: Synchronous active-high reset clears out_valid and the request history. The next request is then treated as a first request.
- R9: Lookahead slots with look_valid low have no effect on the decision, even if their coordinates match the current block.
- R10: Every accepted request yields exactly one result, in acceptance order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted when high with in_valid |
| in_u | input | CW | Texel u coordinate |
| in_v | input | CW | Texel v coordinate |
| look_valid | input | LOOK | Per-slot valid of pending requests |
| look_u | input | LOOK*CW | Pending u coordinates, slot i at [i*CW +: CW] |
| look_v | input | LOOK*CW | Pending v coordinates, slot i at [i*CW +: CW] |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumed when high with out_valid |
| out_cache | output | 1 | 1 = burst-fill cache mode, 0 = single-texel direct mode |
| out_bu | output | CW-EDGE_LOG2 | Block address, u |
| out_bv | output | CW-EDGE_LOG2 | Block address, v |

## Verification
The assertions check the following on every cycle: the handshake hold and ready rules, the block address of each accepted request, the zero-distance and first-request rules, and the forced cache mode for every lookahead slot that matches. The distance thresholds cannot be shown by a property. This covers the products either side of the break-even count, backward steps that would wrap if the distance were signed, and whether history is cleared across a mid-run reset. A scoreboard exercises these with chosen coordinate sequences, some of them under random-looking output backpressure.

// File: rtl/tfm_pkg.sv
package tfm_pkg;

  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_CACHE  = 1'b1
  } fetch_mode_e;

  // Smallest n with cdir * n >= cdir + nblk - 1 (ceiling division).
  function automatic int nacc_min(input int cdir, input int nblk);
    return (cdir + nblk - 1 + cdir - 1) / cdir;
  endfunction

endpackage

// File: rtl/tfm_locality.sv
module tfm_locality #(
  parameter int CW     = 10,
  parameter int NBLOCK = 16,
  parameter int NACC   = 3
) (
  input  logic [CW-1:0] cur_u,
  input  logic [CW-1:0] cur_v,
  input  logic [CW-1:0] prev_u,
  input  logic [CW-1:0] prev_v,
  output logic          dense
);
  localparam int NW = $clog2(NACC + 1) + 1;
  localparam int PW = 2 * CW + NW;

  logic [CW-1:0]   du, dv;
  logic [2*CW-1:0] area;
  logic [PW-1:0]   need;

  always_comb begin
    du   = (cur_u >= prev_u) ? (cur_u - prev_u) : (prev_u - cur_u);
    dv   = (cur_v >= prev_v) ? (cur_v - prev_v) : (prev_v - cur_v);
    area = {{CW{1'b0}}, du} * {{CW{1'b0}}, dv};
    // estimate >= threshold  <=>  NBLOCK >= NACC * du * dv
    need  = PW'(area) * PW'(NACC);
    dense = (du == '0) || (dv == '0) || (need <= PW'(NBLOCK));
  end

endmodule

// File: rtl/tfm_sameblk.sv
module tfm_sameblk #(
  parameter int CW   = 10,
  parameter int SH   = 2,
  parameter int LOOK = 2
) (
  input  logic [CW-1:0]      cur_u,
  input  logic [CW-1:0]      cur_v,
  input  logic [LOOK-1:0]    look_valid,
  input  logic [LOOK*CW-1:0] look_u,
  input  logic [LOOK*CW-1:0] look_v,
  output logic               hit
);
  logic [LOOK-1:0] slot_hit;

  for (genvar i = 0; i < LOOK; i++) begin : g_slot
    logic [CW-1:0] xu, xv;
    assign xu = look_u[i*CW +: CW] ^ cur_u;
    assign xv = look_v[i*CW +: CW] ^ cur_v;
    assign slot_hit[i] = look_valid[i] && ((xu >> SH) == '0) && ((xv >> SH) == '0);
  end

  assign hit = |slot_hit;

endmodule

// File: rtl/tfm_outreg.sv
module tfm_outreg #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          d_cache,
  input  logic [AW-1:0] d_bu,
  input  logic [AW-1:0] d_bv,
  input  logic          q_ready,
  output logic          can_load,
  output logic          q_valid,
  output logic          q_cache,
  output logic [AW-1:0] q_bu,
  output logic [AW-1:0] q_bv
);
  assign can_load = !q_valid || q_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_cache <= 1'b0;
      q_bu    <= '0;
      q_bv    <= '0;
    end else if (can_load) begin
      q_valid <= load;
      if (load) begin
        q_cache <= d_cache;
        q_bu    <= d_bu;
        q_bv    <= d_bv;
      end
    end
  end

endmodule

// File: rtl/texfetch_mode_sel.sv
module texfetch_mode_sel #(
  parameter int CW        = 10,
  parameter int EDGE_LOG2 = 2,
  parameter int CDIRECT   = 8,
  parameter int LOOK      = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [CW-1:0]             in_u,
  input  logic [CW-1:0]             in_v,
  input  logic [LOOK-1:0]           look_valid,
  input  logic [LOOK*CW-1:0]        look_u,
  input  logic [LOOK*CW-1:0]        look_v,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic                      out_cache,
  output logic [CW-EDGE_LOG2-1:0]   out_bu,
  output logic [CW-EDGE_LOG2-1:0]   out_bv
);
  import tfm_pkg::*;

  localparam int NBLOCK = 1 << (2 * EDGE_LOG2);
  localparam int NACC   = nacc_min(CDIRECT, NBLOCK);
  localparam int AW     = CW - EDGE_LOG2;

  logic          accept;
  logic [CW-1:0] prev_u, prev_v;
  logic          have_prev;
  logic          dense, blk_hit;
  fetch_mode_e   mode;

  assign accept = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_u    <= '0;
      prev_v    <= '0;
      have_prev <= 1'b0;
    end else if (accept) begin
      prev_u    <= in_u;
      prev_v    <= in_v;
      have_prev <= 1'b1;
    end
  end

  tfm_locality #(.CW(CW), .NBLOCK(NBLOCK), .NACC(NACC)) u_loc (
    .cur_u (in_u),
    .cur_v (in_v),
    .prev_u(prev_u),
    .prev_v(prev_v),
    .dense (dense)
  );

  tfm_sameblk #(.CW(CW), .SH(EDGE_LOG2), .LOOK(LOOK)) u_sbt (
    .cur_u     (in_u),
    .cur_v     (in_v),
    .look_valid(look_valid),
    .look_u    (look_u),
    .look_v    (look_v),
    .hit       (blk_hit)
  );

  always_comb begin
    if (blk_hit || (have_prev && dense)) mode = MODE_CACHE;
    else                                 mode = MODE_DIRECT;
  end

  tfm_outreg #(.AW(AW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (in_valid),
    .d_cache (mode == MODE_CACHE),
    .d_bu    (in_u[CW-1:EDGE_LOG2]),
    .d_bv    (in_v[CW-1:EDGE_LOG2]),
    .q_ready (out_ready),
    .can_load(in_ready),
    .q_valid (out_valid),
    .q_cache (out_cache),
    .q_bu    (out_bu),
    .q_bv    (out_bv)
  );

endmodule

// File: rtl/tfm_checker.sv
module tfm_checker #(
  parameter int CW        = 10,
  parameter int EDGE_LOG2 = 2,
  parameter int LOOK      = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [CW-1:0]           in_u,
  input logic [CW-1:0]           in_v,
  input logic [LOOK-1:0]         look_valid,
  input logic [LOOK*CW-1:0]      look_u,
  input logic [LOOK*CW-1:0]      look_v,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic                    out_cache,
  input logic [CW-EDGE_LOG2-1:0] out_bu,
  input logic [CW-EDGE_LOG2-1:0] out_bv
);
  logic          acc;
  logic          seen;
  logic [CW-1:0] pu, pv;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= 1'b0;
      pu   <= '0;
      pv   <= '0;
    end else if (acc) begin
      seen <= 1'b1;
      pu   <= in_u;
      pv   <= in_v;
    end
  end

  a_r7_ready_when_empty: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_cache) &&
                                   $stable(out_bu) && $stable(out_bv)));

  a_r10_accept_gives_result: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid);

  a_r5_block_address: assert property (@(posedge clk) disable iff (rst)
    acc |=> (out_bu == $past(in_u[CW-1:EDGE_LOG2]) &&
             out_bv == $past(in_v[CW-1:EDGE_LOG2])));

  a_r2_zero_delta_cache: assert property (@(posedge clk) disable iff (rst)
    (acc && seen && (in_u == pu || in_v == pv)) |=> out_cache);

  a_r3_first_direct: assert property (@(posedge clk) disable iff (rst)
    (acc && !seen && look_valid == '0) |=> !out_cache);

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid);

  for (genvar i = 0; i < LOOK; i++) begin : g_r4
    a_r4_sbt_slot: assert property (@(posedge clk) disable iff (rst)
      (acc && look_valid[i] &&
       (((look_u[i*CW +: CW] ^ in_u) >> EDGE_LOG2) == '0) &&
       (((look_v[i*CW +: CW] ^ in_v) >> EDGE_LOG2) == '0)) |=> out_cache);
  end

endmodule

bind texfetch_mode_sel tfm_checker #(
  .CW(CW), .EDGE_LOG2(EDGE_LOG2), .LOOK(LOOK)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_u(in_u), .in_v(in_v), .look_valid(look_valid), .look_u(look_u),
  .look_v(look_v), .out_valid(out_valid), .out_ready(out_ready),
  .out_cache(out_cache), .out_bu(out_bu), .out_bv(out_bv)
);

// File: tb/texfetch_mode_sel_test.sv
`timescale 1ns/1ps
module texfetch_mode_sel_test;
  localparam int CW = 10;
  localparam int SH = 2;
  localparam int LOOK = 2;
  localparam int AW = CW - SH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [CW-1:0] in_u = '0, in_v = '0;
  logic [LOOK-1:0] look_valid = '0;
  logic [LOOK*CW-1:0] look_u = '0, look_v = '0;
  logic out_valid, out_cache;
  logic out_ready = 1'b1;
  logic [AW-1:0] out_bu, out_bv;

  always #5 clk = ~clk;

  texfetch_mode_sel #(.CW(CW), .EDGE_LOG2(SH), .CDIRECT(8), .LOOK(LOOK)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_u(in_u), .in_v(in_v), .look_valid(look_valid), .look_u(look_u),
    .look_v(look_v), .out_valid(out_valid), .out_ready(out_ready),
    .out_cache(out_cache), .out_bu(out_bu), .out_bv(out_bv)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit bp_en = 0;
  int bp_cnt = 0;

  logic [2*AW:0] exp_q[$];
  string tag_q[$];

  // reference history
  bit m_have = 0;
  int m_pu = 0, m_pv = 0;

  function automatic int absd(input int a, input int b);
    return (a >= b) ? a - b : b - a;
  endfunction

  // backpressure driven away from both edges
  always @(posedge clk) begin
    #2;
    bp_cnt = bp_cnt + 1;
    if (bp_en) out_ready = ((bp_cnt * 7) % 5) > 1;
    else       out_ready = 1'b1;
  end

  task automatic send(input int u, input int v, input logic [1:0] lk,
                      input int lu0, input int lv0, input int lu1, input int lv1,
                      input string tag);
    bit sbt, cache;
    int du, dv;
    sbt = (lk[0] && (lu0 >> SH) == (u >> SH) && (lv0 >> SH) == (v >> SH)) ||
          (lk[1] && (lu1 >> SH) == (u >> SH) && (lv1 >> SH) == (v >> SH));
    du = absd(u, m_pu);
    dv = absd(v, m_pv);
    if (sbt)                   cache = 1;
    else if (!m_have)          cache = 0;
    else if (du == 0 || dv == 0) cache = 1;
    else                       cache = (3 * du * dv) <= 16;
    in_valid   = 1'b1;
    in_u       = CW'(u);
    in_v       = CW'(v);
    look_valid = lk;
    look_u     = {CW'(lu1), CW'(lu0)};
    look_v     = {CW'(lv1), CW'(lv0)};
    while (!in_ready) @(negedge clk);
    exp_q.push_back({cache, AW'(u >> SH), AW'(v >> SH)});
    tag_q.push_back(tag);
    m_have = 1; m_pu = u; m_pv = v;
    @(negedge clk);
    in_valid   = 1'b0;
    look_valid = '0;
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_have = 0;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R8: reset state out_valid=%0b in_ready=%0b, expected 0 and 1",
               out_valid, in_ready);
    end
  endtask

  // scoreboard monitor
  bit held = 0;
  logic [2*AW:0] held_val;
  always @(negedge clk) begin
    if (rst) held = 0;
    else begin
      if (held) begin
        checks++;
        if (!out_valid || {out_cache, out_bu, out_bv} !== held_val) begin
          fails++;
          $display("FAIL R7: stalled result changed to %h (valid %0b), expected %h",
                   {out_cache, out_bu, out_bv}, out_valid, held_val);
        end
      end
      held = out_valid && !out_ready;
      held_val = {out_cache, out_bu, out_bv};
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R10: unexpected result %h, expected none", held_val);
        end else begin
          logic [2*AW:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({out_cache, out_bu, out_bv} !== e) begin
            fails++;
            $display("FAIL %s: got cache=%0b bu=%0d bv=%0d, expected cache=%0b bu=%0d bv=%0d",
                     t, out_cache, out_bu, out_bv, e[2*AW], e[2*AW-1:AW], e[AW-1:0]);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    send(10, 10, 2'b00, 0, 0, 0, 0, "R3 first no match");
    send(11, 15, 2'b00, 0, 0, 0, 0, "R1 area 5 cache");
    send(13, 18, 2'b00, 0, 0, 0, 0, "R1 area 6 direct");
    send(17, 22, 2'b00, 0, 0, 0, 0, "R1 4x4 direct");
    send(17, 40, 2'b00, 0, 0, 0, 0, "R2 du zero");
    send(10, 40, 2'b00, 0, 0, 0, 0, "R2 dv zero");
    send(8, 38, 2'b00, 0, 0, 0, 0, "R6 backward step");
    send(30, 60, 2'b01, 31, 61, 0, 0, "R4 slot0 override");
    send(100, 100, 2'b10, 101, 101, 0, 0, "R9 invalid slot ignored");
    send(200, 200, 2'b10, 0, 0, 203, 202, "R4 slot1 override");
    send(203, 300, 2'b00, 0, 0, 0, 0, "R1 far direct");
    bp_en = 1;
    send(204, 300, 2'b00, 0, 0, 0, 0, "R10 R2 under stall");
    send(205, 301, 2'b00, 0, 0, 0, 0, "R10 R1 area 1");
    send(300, 500, 2'b00, 0, 0, 0, 0, "R10 R1 far");
    send(301, 502, 2'b00, 0, 0, 0, 0, "R1 area 2");
    send(303, 504, 2'b00, 0, 0, 0, 0, "R1 area 4");
    send(306, 507, 2'b00, 0, 0, 0, 0, "R1 area 9");
    send(307, 510, 2'b00, 0, 0, 0, 0, "R1 area 3");
    send(308, 515, 2'b00, 0, 0, 0, 0, "R1 area 5 boundary");
    send(309, 521, 2'b00, 0, 0, 0, 0, "R1 area 6 boundary");
    send(305, 519, 2'b00, 0, 0, 0, 0, "R6 backward area 8");
    bp_en = 0;
    drain();
    do_reset();
    send(305, 519, 2'b00, 0, 0, 0, 0, "R8 history cleared");
    send(305, 519, 2'b00, 0, 0, 0, 0, "R2 repeat after reset");
    drain();
    do_reset();
    send(500, 500, 2'b01, 502, 503, 0, 0, "R3 first with match");
    send(1023, 1023, 2'b00, 0, 0, 0, 0, "R5 top corner");
    send(0, 1023, 2'b00, 0, 0, 0, 0, "R5 R2 edge");
    drain();
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R10: %0d results missing, expected 0", exp_q.size());
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule